// File: doc/BRIEF.md
# Dual-Convention Multiplexed Bus Write Port

This block is the write side of a small peripheral register bank hung on an 8-bit bus whose address and data travel on the same lines, address first. A static mode pin picks one of two strobe conventions. In split-strobe mode the host uses an address-latch-enable line and separate active-low read and write strobes. In combined-strobe mode it uses an address strobe, a data strobe and a read/write direction line. An active-low chip select qualifies every bus event in both modes. The port cannot be read. Read cycles of either convention leave it untouched.

All bus inputs pass through two-flop synchronizers into the system clock domain and are then edge-detected. Because of this, the host may move the strobes as slowly as it likes, for example when firmware drives them from ordinary port pins. An accepted address is held in an internal latch. An accepted data phase writes the bus byte into one of NREG registers, which drive parallel outputs. Each accepted write also gives a one-clock pulse together with the index of the register written.

Top module: `mux_bus_wr_port`

## Requirements
- R1: After reset every register output is 0 and `wr_pulse` is 0.
- R2: With `mode_sel`=0, the byte on `ad` is taken as the address when `ale` falls while `cs_n` is low. The byte on `ad` is written to that register when `wr_n` rises while `cs_n` and `rd_n` are both high-qualified (`cs_n` low, `rd_n` high).
- R3: With `mode_sel`=1, the address is taken when `as_stb` falls while `cs_n` is low. The data is written when `ds_stb` falls while `cs_n` is low and `rw` is low (0 = write).
- R4: Read activity never changes a register or gives a pulse. This covers `rd_n` pulsed low in mode 0, and `ds_stb` pulsed with `rw`=1 in mode 1.
- R5: A strobe edge seen while `cs_n` is high latches no address and writes nothing.
- R6: Addresses NREG and above are unmapped. A data phase aimed at one changes no register and gives no pulse.
- R7: Each accepted write gives `wr_pulse` high for exactly one clock, with `wr_addr` equal to the register index written.
- R8: A data phase with no new address phase before it writes to the most recently latched address.
- R9: The port works with `cs_n` held low for the entire run.
- R10: The strobes of the convention that is not selected have no effect.
- R11: Strobe phases held for hundreds of clocks are accepted just like short ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 0 = split strobes, 1 = combined strobes; held static |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch enable, split mode |
| rd_n | input | 1 | Active-low read strobe, split mode |
| wr_n | input | 1 | Active-low write strobe, split mode |
| as_stb | input | 1 | Address strobe, combined mode |
| ds_stb | input | 1 | Data strobe, combined mode |
| rw | input | 1 | Direction, combined mode: 1 read, 0 write |
| ad | input | DW (8) | Multiplexed address/data bus |
| regs_o | output | NREG*DW (64) | Register file, register i at bits i*DW +: DW |
| wr_pulse | output | 1 | One-clock pulse per accepted write |
| wr_addr | output | clog2(NREG) (3) | Index of the register just written |

## Verification
The bench builds the block with its defaults: an 8-bit bus, eight registers and two synchronizer stages. With these values, every register can be written in both conventions, and each write can be followed by a full compare of the whole bank against a model computed in the bench. The 8-bit address space also brings the unmapped range within reach, from just past the last register up to 255. In the same sweep the bench covers read cycles, deselected cycles, cross-mode strobes, data-only phases and very long strobe holds.

// File: rtl/msbw_pkg.sv
package msbw_pkg;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_COMB = 1'b1} bus_mode_e;

  // An address is mapped when it names one of the nreg registers.
  function automatic logic addr_hit(input logic [31:0] a, input int unsigned nreg);
    return a < nreg;
  endfunction

  // Register index carried in the low address bits.
  function automatic logic [31:0] reg_index(input logic [31:0] a, input int unsigned nreg);
    return a % nreg;
  endfunction
endpackage

// File: rtl/msbw_sync.sv
module msbw_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msbw_decode.sv
module msbw_decode
  import msbw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_mode_e mode,
  input  logic      cs_n_s,
  input  logic      ale_s,
  input  logic      rd_n_s,
  input  logic      wr_n_s,
  input  logic      as_s,
  input  logic      ds_s,
  input  logic      rw_s,
  output logic      addr_ev,
  output logic      data_ev
);
  logic ale_p, wr_n_p, as_p, ds_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_p  <= 1'b0;
      wr_n_p <= 1'b1;
      as_p   <= 1'b0;
      ds_p   <= 1'b0;
    end else begin
      ale_p  <= ale_s;
      wr_n_p <= wr_n_s;
      as_p   <= as_s;
      ds_p   <= ds_s;
    end
  end

  logic ale_fall, wr_rise, as_fall, ds_fall;
  assign ale_fall = ale_p & ~ale_s;
  assign wr_rise  = ~wr_n_p & wr_n_s;
  assign as_fall  = as_p & ~as_s;
  assign ds_fall  = ds_p & ~ds_s;

  always_comb begin
    addr_ev = 1'b0;
    data_ev = 1'b0;
    if (!cs_n_s) begin
      if (mode == MODE_SPLIT) begin
        addr_ev = ale_fall;
        data_ev = wr_rise & rd_n_s;
      end else begin
        addr_ev = as_fall;
        data_ev = ds_fall & ~rw_s;
      end
    end
  end
endmodule

// File: rtl/msbw_regfile.sv
module msbw_regfile #(
  parameter int DW = 8,
  parameter int NREG = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g*DW +: DW] <= '0;
      else if (we && widx == IDX_W'(g)) regs[g*DW +: DW] <= wdata;
    end
  end

  // R6: with no write enable the bank holds every bit
  p_regs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

// File: rtl/mux_bus_wr_port.sv
module mux_bus_wr_port
  import msbw_pkg::*;
#(
  parameter int DW = 8,
  parameter int NREG = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(NREG),
  localparam int SW = DW + 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_sel,
  input  logic               cs_n,
  input  logic               ale,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               as_stb,
  input  logic               ds_stb,
  input  logic               rw,
  input  logic [DW-1:0]      ad,
  output logic [NREG*DW-1:0] regs_o,
  output logic               wr_pulse,
  output logic [IDX_W-1:0]   wr_addr
);
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, {DW{1'b0}}};

  logic [SW-1:0] raw_v, syn_v;
  assign raw_v = {cs_n, ale, rd_n, wr_n, as_stb, ds_stb, rw, ad};

  msbw_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
  );

  logic cs_n_s, ale_s, rd_n_s, wr_n_s, as_s, ds_s, rw_s;
  logic [DW-1:0] ad_s;
  assign {cs_n_s, ale_s, rd_n_s, wr_n_s, as_s, ds_s, rw_s, ad_s} = syn_v;

  // Named internal events
  logic addr_ev, data_ev, addr_hit_w, we;

  msbw_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode(bus_mode_e'(mode_sel)),
    .cs_n_s(cs_n_s), .ale_s(ale_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
    .as_s(as_s), .ds_s(ds_s), .rw_s(rw_s),
    .addr_ev(addr_ev), .data_ev(data_ev)
  );

  logic [DW-1:0] addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ev) addr_q <= ad_s;
  end

  assign addr_hit_w = addr_hit(32'(addr_q), NREG);
  assign we = data_ev & addr_hit_w;

  logic [IDX_W-1:0] widx;
  assign widx = IDX_W'(reg_index(32'(addr_q), NREG));

  msbw_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(ad_s), .regs(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
    end else begin
      wr_pulse <= we;
      if (we) wr_addr <= widx;
    end
  end

  // R7: a pulse never lasts beyond one clock
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  // R7: a pulse is always preceded by a data event
  p_pulse_after_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(data_ev));
  // R6: a data event aimed at an unmapped address is dropped
  p_drop_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ev && !addr_hit_w) |=> !wr_pulse);
  // R8: the latched address moves only on an address event
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ev |=> $stable(addr_q));
endmodule

// File: tb/sim_mux_bus_wr_port.sv
`timescale 1ns/1ps
module sim_mux_bus_wr_port;
  localparam int DW = 8;
  localparam int NREG = 8;

  logic clk = 0, rst_n = 0, mode_sel = 0, cs_n = 1, ale = 0, rd_n = 1, wr_n = 1;
  logic as_stb = 0, ds_stb = 0, rw = 1;
  logic [DW-1:0] ad = '0;
  logic [NREG*DW-1:0] regs_o;
  logic wr_pulse;
  logic [2:0] wr_addr;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  logic [DW-1:0] mdl [NREG];

  always #2 clk = ~clk;

  mux_bus_wr_port u0 (.*);

  always @(posedge clk) if (wr_pulse) n_pulse++;

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(regs_o[i*DW +: DW]), 32'(mdl[i]));
  endtask

  // split mode cycle; do_addr=0 skips the address phase
  task automatic cyc_split(input logic [7:0] a, input logic [7:0] d, input logic sel_n,
                           input bit do_addr, input int hold);
    cs_n = sel_n;
    if (do_addr) begin
      ad = a; ale = 1; w(hold); ale = 0; w(hold);
    end
    ad = d; wr_n = 0; w(hold); wr_n = 1; w(hold);
    cs_n = 1; w(4);
  endtask

  // combined mode cycle; r=1 makes it a read; keep_cs holds select low
  task automatic cyc_comb(input logic [7:0] a, input logic [7:0] d, input logic r, input bit keep_cs);
    cs_n = 0;
    ad = a; as_stb = 1; w(4); as_stb = 0; w(4);
    ad = d; rw = r; ds_stb = 1; w(4); ds_stb = 0; w(4);
    rw = 1;
    if (!keep_cs) cs_n = 1;
    w(4);
  endtask

  initial begin
    int p0;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    w(5); rst_n = 1; w(5);
    // R1 reset state
    chk_bank("R1");
    chk("R1", 32'(wr_pulse), 0);

    // R2/R7 split-mode sweep over every register
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] d = 8'((i * 37 + 5) & 255);
      p0 = n_pulse;
      cyc_split(8'(i), d, 0, 1, 4);
      mdl[i] = d;
      chk("R2", 32'(regs_o[i*DW +: DW]), 32'(d));
      chk("R7", n_pulse - p0, 1);
      chk("R7", 32'(wr_addr), 32'(i));
    end
    chk_bank("R2");

    // R6 unmapped addresses
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a = (k == 3) ? 8'd255 : 8'(NREG + k * 40);
      p0 = n_pulse;
      cyc_split(a, 8'hEE, 0, 1, 4);
      chk("R6", n_pulse - p0, 0);
    end
    chk_bank("R6");

    // R4 read strobe in split mode after latching address 3
    p0 = n_pulse;
    cs_n = 0; ad = 8'd3; ale = 1; w(4); ale = 0; w(4);
    ad = 8'h5A; rd_n = 0; w(4); rd_n = 1; w(4); cs_n = 1; w(4);
    chk("R4", n_pulse - p0, 0);
    chk_bank("R4");

    // R5 deselected cycle aimed at register 2
    p0 = n_pulse;
    cyc_split(8'd2, 8'h77, 1, 1, 4);
    chk("R5", n_pulse - p0, 0);
    chk_bank("R5");

    // R8 data-only phase goes to last latched address (3, not 2)
    p0 = n_pulse;
    cyc_split(8'd0, 8'hC3, 0, 0, 4);
    mdl[3] = 8'hC3;
    chk("R8", n_pulse - p0, 1);
    chk("R8", 32'(wr_addr), 3);
    chk_bank("R8");

    // R11 very slow strobes
    p0 = n_pulse;
    cyc_split(8'd6, 8'h96, 0, 1, 700);
    mdl[6] = 8'h96;
    chk("R11", n_pulse - p0, 1);
    chk_bank("R11");

    // R10 split strobes ignored in combined mode
    mode_sel = 1; w(6);
    p0 = n_pulse;
    cyc_split(8'd1, 8'h11, 0, 1, 4);
    chk("R10", n_pulse - p0, 0);
    chk_bank("R10");

    // R3/R9 combined-mode sweep with select held low throughout
    cs_n = 0; w(4);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] d = 8'((i * 91 + 200) & 255);
      p0 = n_pulse;
      cyc_comb(8'(i), d, 0, 1);
      mdl[i] = d;
      chk("R3", 32'(regs_o[i*DW +: DW]), 32'(d));
      chk("R9", n_pulse - p0, 1);
      chk("R7", 32'(wr_addr), 32'(i));
    end
    chk_bank("R9");

    // R4 combined-mode read, R6 combined-mode unmapped
    p0 = n_pulse;
    cyc_comb(8'd5, 8'h3C, 1, 1);
    chk("R4", n_pulse - p0, 0);
    cyc_comb(8'd9, 8'h3C, 0, 1);
    chk("R6", n_pulse - p0, 0);
    chk_bank("R4");

    // R10 combined strobes ignored in split mode
    cs_n = 1; w(4);
    mode_sel = 0; w(6);
    p0 = n_pulse;
    cyc_comb(8'd4, 8'h44, 0, 0);
    chk("R10", n_pulse - p0, 0);
    chk_bank("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule